// File: doc/BRIEF.md
# Modulo Alarm Timer

This block is a register-programmed 16-bit up-counter meant to serve as a one-shot alarm source. Software sets a start value and a limit value, picks a count clock and a power-of-two prescaler, and then waits for the overflow flag or its interrupt. The counter does not wrap to zero. When it sits at the limit, the next tick reloads the start value, and that same tick is the overflow event. With start 0 and limit N-1, the first overflow therefore comes after exactly N ticks.

The overflow flag can be set to fire only on every (T+1)-th overflow, using a skip threshold T. Software clears the flag in two steps: it reads the control register while the flag is set, then writes the flag bit as 0. The clear never wins against an overflow that happens in the same cycle. The interrupt output is the flag gated by an enable bit, presented from a register.

The host uses a simple synchronous register port. A read returns data one cycle after the read strobe. Register offsets on `bus_addr`: 0 control, 1 count, 2 start, 3 limit, 4 skip threshold. Any other offset reads 0.

Top module: `alarm_timer`

## Requirements
- R1: After reset, control, count, start and threshold read 0, limit reads 0x0000FFFF and `irq` is 0.
- R2: On each tick the count increments while it differs from the limit. A tick with count equal to the limit loads the start value instead.
- R3: The overflow event is the tick that moves the count from the limit to the start value. With the start value at S and the limit at S+N-1, that is the N-th tick.
- R4: A write to the count register (offset 1) loads the start value and ignores the written data. A count read returns zero in bits 31:16.
- R5: Control bits 1:0 select the tick source. Code 0 and code 3 stop the count. Code 1 counts the system clock every cycle. Code 2 counts cycles in which `ref_pulse` is 1.
- R6: Control bits 4:2 hold PS. One tick occurs per 2^PS source events.
- R7: Writing the control register with source code 0 clears the prescaler. After a re-enable, the first tick comes a full 2^PS events later.
- R8: Control bit 6 enables the interrupt. `irq` equals flag AND enable, as they stood one cycle earlier.
- R9: Control bit 7 shows the flag. It clears only on a control write with bit 7 equal to 0 that follows a control read that saw the flag set. A write without such a read, or a write of 1, leaves the flag unchanged.
- R10: The threshold register (bits 4:0) holds T. The flag sets on the overflow that finds T overflows already skipped, so on every (T+1)-th overflow.
- R11: A clear write that lands in the same cycle as an overflow event leaves the flag set, whatever the skip count.
- R12: Writes to reserved bits are ignored, and reserved bits read 0. Start and limit keep bits 15:0 only. Control keeps bits 7:6 and 4:0. Threshold keeps bits 4:0. Bit 7 is the flag and is never written directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Fixed-frequency reference, one-cycle strobes synchronous to clk |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq | output | 1 | Registered overflow interrupt |

## Verification
The hardest case to reach from the ports is a clear write that lands exactly on an overflow tick while the skip count is below a nonzero threshold. To get there, the bench selects the reference-pulse source with PS = 0, so that every `ref_pulse` strobe is one tick. It sets the limit to 1 and a threshold of 2, and arms the clear with a status read. It then steps the count onto the limit and drives the final strobe and the clear write in the same clock cycle. The prescaler reset is reached the same way: the bench stops the source partway through a prescale period and counts the strobes needed after re-enabling it.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_START = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LIMIT = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_SKIP  = 3'd4;

  typedef enum logic [1:0] {
    SRC_OFF = 2'd0,
    SRC_SYS = 2'd1,
    SRC_REF = 2'd2,
    SRC_RSV = 2'd3
  } src_e;
endpackage

// File: rtl/alarm_prescaler.sv
module alarm_prescaler
  import alarm_pkg::*;
#(
  parameter int unsigned PSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  src_e           src_i,
  input  logic [PSW-1:0] ps_i,
  input  logic           ref_pulse_i,
  input  logic           clr_i,
  output logic           tick_o
);
  localparam int unsigned DIVW = (1 << PSW) - 1;
  localparam logic [DIVW:0]   ONE_W = 1;
  localparam logic [DIVW-1:0] ONE_D = 1;

  logic [DIVW-1:0] pre_q;
  logic [DIVW:0]   mask_full;
  logic [DIVW-1:0] mask;
  logic            evt;

  always_comb begin
    unique case (src_i)
      SRC_SYS: evt = 1'b1;
      SRC_REF: evt = ref_pulse_i;
      default: evt = 1'b0;
    endcase
    mask_full = (ONE_W << ps_i) - ONE_W;
    mask      = mask_full[DIVW-1:0];
    tick_o    = evt && (pre_q >= mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      pre_q <= '0;
    end else if (evt) begin
      pre_q <= tick_o ? '0 : pre_q + ONE_D;
    end
  end
endmodule

// File: rtl/alarm_counter.sv
module alarm_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          load_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] limit_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam logic [CW-1:0] ONE_C = 1;

  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == limit_i);
  assign wrap_o   = tick_i && !load_i && at_limit;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= start_i;
    end else if (tick_i) begin
      cnt_q <= at_limit ? start_i : cnt_q + ONE_C;
    end
  end
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag #(
  parameter int unsigned TW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap_i,
  input  logic [TW-1:0] thr_i,
  input  logic          rd_ctrl_i,
  input  logic          wr_ctrl_i,
  input  logic          wr_flag_i,
  input  logic          en_i,
  output logic          flag_o,
  output logic          irq_o
);
  localparam logic [TW-1:0] ONE_T = 1;

  logic [TW-1:0] skip_q;
  logic          flag_q;
  logic          armed_q;
  logic          irq_q;
  logic          hit;
  logic          clr_ok;

  assign hit    = wrap_i && (skip_q >= thr_i);
  assign clr_ok = wr_ctrl_i && armed_q && !wr_flag_i && !wrap_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      skip_q  <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (wrap_i) skip_q <= hit ? '0 : skip_q + ONE_T;
      if (hit)         flag_q <= 1'b1;
      else if (clr_ok) flag_q <= 1'b0;
      if (wr_ctrl_i)                  armed_q <= 1'b0;
      else if (rd_ctrl_i && flag_q)   armed_q <= 1'b1;
      irq_q <= flag_q && en_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/alarm_timer.sv
module alarm_timer
  import alarm_pkg::*;
#(
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3,
  parameter int unsigned TW  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_pulse,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq
);
  localparam int unsigned PS_LSB   = 2;
  localparam int unsigned EN_BIT   = PS_LSB + PSW + 1;
  localparam int unsigned FLAG_BIT = EN_BIT + 1;

  src_e             src_q;
  logic [PSW-1:0]   ps_q;
  logic             en_q;
  logic [CW-1:0]    start_q;
  logic [CW-1:0]    limit_q;
  logic [TW-1:0]    thr_q;
  logic [CW-1:0]    cnt_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] ctrl_word;
  logic             tick;
  logic             wrap;
  logic             flag_q;
  logic             wr_ctrl;
  logic             wr_count;
  logic             rd_ctrl;
  logic             pre_clr;

  assign wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_count = bus_wr && (bus_addr == ADDR_COUNT);
  assign rd_ctrl  = bus_rd && (bus_addr == ADDR_CTRL);
  assign pre_clr  = wr_ctrl && (bus_wdata[1:0] == SRC_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= SRC_OFF;
      ps_q    <= '0;
      en_q    <= 1'b0;
      start_q <= '0;
      limit_q <= '1;
      thr_q   <= '0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        ADDR_CTRL: begin
          src_q <= src_e'(bus_wdata[1:0]);
          ps_q  <= bus_wdata[PS_LSB +: PSW];
          en_q  <= bus_wdata[EN_BIT];
        end
        ADDR_START: start_q <= bus_wdata[CW-1:0];
        ADDR_LIMIT: limit_q <= bus_wdata[CW-1:0];
        ADDR_SKIP:  thr_q   <= bus_wdata[TW-1:0];
        default: ;
      endcase
    end
  end

  alarm_prescaler #(.PSW(PSW)) u_pre (
    .clk        (clk),
    .rst        (rst),
    .src_i      (src_q),
    .ps_i       (ps_q),
    .ref_pulse_i(ref_pulse),
    .clr_i      (pre_clr),
    .tick_o     (tick)
  );

  alarm_counter #(.CW(CW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .tick_i (tick),
    .load_i (wr_count),
    .start_i(start_q),
    .limit_i(limit_q),
    .cnt_o  (cnt_q),
    .wrap_o (wrap)
  );

  alarm_flag #(.TW(TW)) u_flag (
    .clk      (clk),
    .rst      (rst),
    .wrap_i   (wrap),
    .thr_i    (thr_q),
    .rd_ctrl_i(rd_ctrl),
    .wr_ctrl_i(wr_ctrl),
    .wr_flag_i(bus_wdata[FLAG_BIT]),
    .en_i     (en_q),
    .flag_o   (flag_q),
    .irq_o    (irq)
  );

  always_comb begin
    ctrl_word                    = '0;
    ctrl_word[1:0]               = src_q;
    ctrl_word[PS_LSB +: PSW]     = ps_q;
    ctrl_word[EN_BIT]            = en_q;
    ctrl_word[FLAG_BIT]          = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        ADDR_CTRL:  rdata_q <= ctrl_word;
        ADDR_COUNT: rdata_q <= DATA_W'(cnt_q);
        ADDR_START: rdata_q <= DATA_W'(start_q);
        ADDR_LIMIT: rdata_q <= DATA_W'(limit_q);
        ADDR_SKIP:  rdata_q <= DATA_W'(thr_q);
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/alarm_timer_checker.sv
module alarm_timer_checker
  import alarm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     start,
  input logic [CW-1:0]     limit,
  input logic              tick,
  input logic              wrap,
  input logic              flag,
  input logic              en,
  input logic [1:0]        src
);
  logic cwr;
  assign cwr = bus_wr && (bus_addr == ADDR_COUNT);

  AST_COUNT_WRITE_LOADS: assert property (@(posedge clk) disable iff (rst)
    cwr |=> (cnt == $past(start))); // R4

  AST_COUNT_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_COUNT) |=> (bus_rdata[31:16] == 16'h0)); // R4

  AST_LIMIT_RELOADS: assert property (@(posedge clk) disable iff (rst)
    (tick && !cwr && cnt == limit) |=> (cnt == $past(start))); // R2

  AST_FLAG_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(wrap)); // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ((src == 2'd0 || src == 2'd3) && !cwr) |=> $stable(cnt)); // R5

  AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
    (flag && en) |=> irq); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(flag && en) |=> !irq); // R8

  AST_WRAP_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (wrap && flag) |=> flag); // R11
endmodule

bind alarm_timer alarm_timer_checker #(.CW(CW)) u_alarm_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq      (irq),
  .cnt      (cnt_q),
  .start    (start_q),
  .limit    (limit_q),
  .tick     (tick),
  .wrap     (wrap),
  .flag     (flag_q),
  .en       (en_q),
  .src      (src_q)
);

// File: tb/alarm_timer_bench.sv
module alarm_timer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_pulse = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_timer u_alarm_timer (
    .clk(clk), .rst(rst), .ref_pulse(ref_pulse), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // monitor: pops expected read data when a read result becomes valid
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, actual %h expected none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ref_pulse = 1'b1;
      @(negedge clk);
      ref_pulse = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(3'd0, 32'h0, "R1 control");
    rd(3'd1, 32'h0, "R1 count");
    rd(3'd2, 32'h0, "R1 start");
    rd(3'd3, 32'h0000FFFF, "R1 limit");
    rd(3'd4, 32'h0, "R1 threshold");
    // R12 reserved bits
    wr(3'd2, 32'hABCD1234);
    rd(3'd2, 32'h00001234, "R12 start width");
    wr(3'd0, 32'hFFFFFF20);
    rd(3'd0, 32'h0, "R12 control reserved and flag write");
    wr(3'd4, 32'hFFFFFFE3);
    rd(3'd4, 32'h3, "R12 threshold width");
    wr(3'd4, 32'h0);
    rd(3'd5, 32'h0, "R12 unmapped offset");
    // R4 count write loads start
    wr(3'd2, 32'h5);
    wr(3'd3, 32'h8);
    wr(3'd1, 32'hDEAD);
    rd(3'd1, 32'h5, "R4 count write loads start");
    // R2/R3 counting and wrap with reference source, PS=0
    wr(3'd0, 32'h02);
    pulses(3);
    rd(3'd1, 32'h8, "R2 counts to limit");
    rd(3'd0, 32'h02, "R3 no flag before wrap");
    pulses(1);
    rd(3'd1, 32'h5, "R2 reload start at limit");
    // R9 clear without prior read is ignored
    wr(3'd0, 32'h02);
    rd(3'd0, 32'h82, "R9 clear without read ignored / R3 flag set");
    chk_irq(1'b0, "R8 irq gated off");
    wr(3'd0, 32'hC2);
    chk_irq(1'b0, "R8 irq registered lag");
    @(negedge clk);
    chk_irq(1'b1, "R8 irq on flag and enable");
    rd(3'd0, 32'hC2, "R9 writing 1 does not clear");
    wr(3'd0, 32'h42);
    rd(3'd0, 32'h42, "R9 read then write 0 clears");
    chk_irq(1'b0, "R8 irq drops after clear");
    // R6 prescaler PS=2
    wr(3'd0, 32'h4A);
    pulses(3);
    rd(3'd1, 32'h5, "R6 no tick before 4 events");
    pulses(1);
    rd(3'd1, 32'h6, "R6 tick on 4th event");
    // R7 prescaler cleared by source off
    pulses(2);
    wr(3'd0, 32'h40);
    pulses(2);
    rd(3'd1, 32'h6, "R5 source off stops count");
    wr(3'd0, 32'h4A);
    pulses(3);
    rd(3'd1, 32'h6, "R7 prescaler restarted");
    pulses(1);
    rd(3'd1, 32'h7, "R7 full period after enable");
    // R5 system clock source, PS=2
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h49);
    repeat (10) @(negedge clk);
    rd(3'd1, 32'h7, "R5 system clock ticks");
    wr(3'd0, 32'h40);
    rd(3'd1, 32'h8, "R5 stop after source off");
    repeat (5) @(negedge clk);
    rd(3'd1, 32'h8, "R5 stays stopped");
    // R10 skip threshold
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h1);
    wr(3'd4, 32'h2);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h42);
    pulses(4);
    rd(3'd0, 32'h42, "R10 two overflows skipped");
    chk_irq(1'b0, "R10 irq quiet while skipping");
    pulses(2);
    rd(3'd0, 32'hC2, "R10 flag on third overflow");
    chk_irq(1'b1, "R10 irq on third overflow");
    // R11 clear coinciding with overflow
    pulses(1);
    bus_addr = 3'd0; bus_wdata = 32'h42; bus_wr = 1'b1; ref_pulse = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; ref_pulse = 1'b0;
    rd(3'd0, 32'hC2, "R11 clear on overflow ignored");
    rd(3'd1, 32'h0, "R11 wrap happened");
    wr(3'd0, 32'h42);
    rd(3'd0, 32'h42, "R11 later clear works");
    done = 1;
    finish_run();
  end
endmodule